// File: doc/BRIEF.md
# Output Voltage Window Supervisor

This block supervises the regulated output of a buck converter through five comparator flags from an analog front end. One flag reports the sense voltage above the overvoltage level. One reports it below the undervoltage level. Two report it above the upper or below the lower power-good level. The last reports it below half of the reference. The block drives a power-good output and two latched fault outputs. It also issues override requests to the gate drivers: force the high-side gate off, force the low-side gate on, or force the low-side gate off.

Every flag passes through a two-flop synchronizer and a glitch filter before it can affect anything. An overvoltage forces the high-side gate off and the low-side gate on. The low side is released only when the sense voltage drops below half the reference. It is re-engaged each time the overvoltage flag returns, and the fault itself stays latched until the supply is cycled. An undervoltage, once soft-start is complete, forces both gates off and also latches. Leaving the power-good window only lowers power-good; it never overrides a gate. The reset input stands for the supply being invalid, so a supply cycle clears every latch.

Top module: `vout_window_supervisor`

## Requirements
- R1: Each flag goes through a 2-flop synchronizer and is ignored unless it holds a new value for at least 2 consecutive cycles. A 1-cycle pulse changes no output. A flag change that holds steady reaches the registered outputs on the 5th rising edge after it is first sampled.
- R2: A filtered overvoltage flag sets `ov_fault_o`, which stays high until reset.
- R3: `hs_off_o` is high whenever either fault is latched.
- R4: `ls_on_o` rises with an accepted overvoltage. It falls only when the filtered below-half flag is high and the filtered overvoltage flag is low.
- R5: After a release, `ls_on_o` rises again whenever the overvoltage flag returns while `ov_fault_o` is still latched.
- R6: A filtered undervoltage flag sets `uv_fault_o` while `ss_done_i` is high. The fault stays until reset, and `ls_off_o` is high while it is latched and `ls_on_o` is low.
- R7: The undervoltage flag has no effect while `ss_done_i` is low.
- R8: If overvoltage and undervoltage are accepted on the same edge, only `ov_fault_o` latches. `uv_fault_o` never sets while `ov_fault_o` is latched.
- R9: `pgood_o` is high after an edge only if, at that edge, `ss_done_i` was high, no filtered flag other than below-half was high, and no fault was latched. A window excursion alone lowers `pgood_o` and leaves all gate overrides low.
- R10: `ls_on_o` and `ls_off_o` are never high together. An overvoltage during a latched undervoltage turns the low side on.
- R11: Reset clears all outputs to 0. An overvoltage flag held high from reset release (a floating sense pin) holds `ls_on_o` high continuously once accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, high while supply is invalid |
| ov_flag_i | input | 1 | Sense above overvoltage level (asynchronous) |
| uv_flag_i | input | 1 | Sense below undervoltage level (asynchronous) |
| pg_hi_flag_i | input | 1 | Sense above upper power-good level (asynchronous) |
| pg_lo_flag_i | input | 1 | Sense below lower power-good level (asynchronous) |
| half_ref_flag_i | input | 1 | Sense below half of the reference (asynchronous) |
| ss_done_i | input | 1 | Soft-start complete, synchronous to clk |
| pgood_o | output | 1 | Power-good |
| ov_fault_o | output | 1 | Latched overvoltage fault |
| uv_fault_o | output | 1 | Latched undervoltage fault |
| hs_off_o | output | 1 | Request to hold the high-side gate off |
| ls_on_o | output | 1 | Request to force the low-side gate on |
| ls_off_o | output | 1 | Request to hold the low-side gate off |

## Verification
Some properties are checked on every cycle:
- the stickiness of the overvoltage fault;
- the masking of undervoltage before soft-start and while overvoltage is latched;
- the condition under which the low-side hold may fall;
- the exclusivity of the two low-side requests;
- that a filter output only moves toward a value its synchronizer already showed.

Other behaviour only the bench scenarios can show. These are the exact five-edge latency, the rejection of single-cycle pulses, the re-engagement of the low side after a release, the simultaneous-fault priority and the floating-pin case. The bench shows them by driving those sequences against a behavioural model and explicit expected values.

// File: rtl/vws_pkg.sv
package vws_pkg;

    localparam int NUM_FLAGS   = 5;
    localparam int SYNC_DEPTH  = 2;
    localparam int FILTER_LEN  = 2;

    // Bit positions of the flag vector (ov is bit 0)
    typedef struct packed {
        logic half_ref;
        logic pg_lo;
        logic pg_hi;
        logic uv;
        logic ov;
    } sense_flags_t;

    typedef enum logic [1:0] {
        LS_NORMAL    = 2'd0,
        LS_FORCE_ON  = 2'd1,
        LS_FORCE_OFF = 2'd2
    } ls_mode_e;

    typedef struct packed {
        logic     hs_off;
        ls_mode_e ls_mode;
    } gate_req_t;

    function automatic logic window_ok(input logic above_hi, input logic below_lo);
        return !above_hi && !below_lo;
    endfunction

endpackage

// File: rtl/vws_flag_filter.sv
module vws_flag_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] chain_q;
    logic [CW-1:0]          run_q;
    logic                   filt_q;
    logic                   synced;

    assign synced = chain_q[SYNC_STAGES-1];
    assign filt_o = filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= (chain_q << 1) | SYNC_STAGES'(raw_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            filt_q <= 1'b0;
        end else if (synced == filt_q) begin
            run_q  <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            filt_q <= synced;
            run_q  <= '0;
        end else begin
            run_q  <= run_q + CW'(1);
        end
    end

    // R1
    filt_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> ($past(synced) == filt_q));

endmodule

// File: rtl/vws_fault_ctrl.sv
module vws_fault_ctrl
    import vws_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ov_i,
    input  logic      uv_i,
    input  logic      half_i,
    input  logic      ss_done_i,
    output logic      ov_fault_o,
    output logic      uv_fault_o,
    output gate_req_t req_o
);
    logic ov_lat_q, uv_lat_q, ls_hold_q;
    logic uv_arm;

    // Undervoltage is armed only after soft-start and never against overvoltage
    assign uv_arm = uv_i && ss_done_i && !ov_i && !ov_lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_lat_q  <= 1'b0;
            uv_lat_q  <= 1'b0;
            ls_hold_q <= 1'b0;
        end else begin
            if (ov_i)
                ov_lat_q <= 1'b1;
            if (uv_arm)
                uv_lat_q <= 1'b1;
            if (ov_i)
                ls_hold_q <= 1'b1;
            else if (half_i)
                ls_hold_q <= 1'b0;
        end
    end

    always_comb begin
        req_o.hs_off = ov_lat_q || uv_lat_q;
        if (ls_hold_q)
            req_o.ls_mode = LS_FORCE_ON;
        else if (uv_lat_q)
            req_o.ls_mode = LS_FORCE_OFF;
        else
            req_o.ls_mode = LS_NORMAL;
    end

    assign ov_fault_o = ov_lat_q;
    assign uv_fault_o = uv_lat_q;

    // R2
    ov_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ov_lat_q |=> ov_lat_q);

    // R6
    uv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        uv_lat_q |=> uv_lat_q);

    // R7
    uv_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (!uv_lat_q && !ss_done_i) |=> !uv_lat_q);

    // R8
    ov_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (!uv_lat_q && (ov_lat_q || ov_i)) |=> !uv_lat_q);

    // R4
    ls_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ls_hold_q) |-> ($past(half_i) && !$past(ov_i)));

endmodule

// File: rtl/vws_pgood_gen.sv
module vws_pgood_gen
    import vws_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ss_done_i,
    input  logic ov_i,
    input  logic uv_i,
    input  logic pg_hi_i,
    input  logic pg_lo_i,
    input  logic any_fault_i,
    output logic pgood_o
);
    logic pgood_q;

    always_ff @(posedge clk) begin
        if (rst)
            pgood_q <= 1'b0;
        else
            pgood_q <= ss_done_i && window_ok(pg_hi_i, pg_lo_i)
                       && !ov_i && !uv_i && !any_fault_i;
    end

    assign pgood_o = pgood_q;

    // R9
    pgood_after_ss_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pgood_q) |-> $past(ss_done_i));

    // R9
    pgood_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        $past(any_fault_i) |-> !pgood_q);

endmodule

// File: rtl/vout_window_supervisor.sv
module vout_window_supervisor
    import vws_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ov_flag_i,
    input  logic uv_flag_i,
    input  logic pg_hi_flag_i,
    input  logic pg_lo_flag_i,
    input  logic half_ref_flag_i,
    input  logic ss_done_i,
    output logic pgood_o,
    output logic ov_fault_o,
    output logic uv_fault_o,
    output logic hs_off_o,
    output logic ls_on_o,
    output logic ls_off_o
);
    logic [NUM_FLAGS-1:0] raw_vec;
    logic [NUM_FLAGS-1:0] filt_vec;
    sense_flags_t         flt;
    gate_req_t            req;
    logic                 ov_fault, uv_fault;

    assign raw_vec = {half_ref_flag_i, pg_lo_flag_i, pg_hi_flag_i, uv_flag_i, ov_flag_i};

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        vws_flag_filter #(
            .SYNC_STAGES (SYNC_DEPTH),
            .FILT_LEN    (FILTER_LEN)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_vec[g]),
            .filt_o (filt_vec[g])
        );
    end

    assign flt = sense_flags_t'(filt_vec);

    vws_fault_ctrl u_fault (
        .clk        (clk),
        .rst        (rst),
        .ov_i       (flt.ov),
        .uv_i       (flt.uv),
        .half_i     (flt.half_ref),
        .ss_done_i  (ss_done_i),
        .ov_fault_o (ov_fault),
        .uv_fault_o (uv_fault),
        .req_o      (req)
    );

    vws_pgood_gen u_pg (
        .clk         (clk),
        .rst         (rst),
        .ss_done_i   (ss_done_i),
        .ov_i        (flt.ov),
        .uv_i        (flt.uv),
        .pg_hi_i     (flt.pg_hi),
        .pg_lo_i     (flt.pg_lo),
        .any_fault_i (ov_fault || uv_fault),
        .pgood_o     (pgood_o)
    );

    assign ov_fault_o = ov_fault;
    assign uv_fault_o = uv_fault;
    assign hs_off_o   = req.hs_off;
    assign ls_on_o    = (req.ls_mode == LS_FORCE_ON);
    assign ls_off_o   = (req.ls_mode == LS_FORCE_OFF);

    // R10
    ls_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(ls_on_o && ls_off_o));

    // R3
    hs_off_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (ov_fault_o || uv_fault_o) |-> hs_off_o);

endmodule

// File: tb/vout_window_supervisor_bench.sv
module vout_window_supervisor_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ov = 0, uv = 0, pghi = 0, pglo = 0, half = 0, ss = 0;
    logic pgood, ov_fault, uv_fault, hs_off, ls_on, ls_off;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vout_window_supervisor u_vout_window_supervisor (
        .clk(clk), .rst(rst),
        .ov_flag_i(ov), .uv_flag_i(uv), .pg_hi_flag_i(pghi),
        .pg_lo_flag_i(pglo), .half_ref_flag_i(half), .ss_done_i(ss),
        .pgood_o(pgood), .ov_fault_o(ov_fault), .uv_fault_o(uv_fault),
        .hs_off_o(hs_off), .ls_on_o(ls_on), .ls_off_o(ls_off)
    );

    // ---------------- behavioural reference model ----------------
    logic [4:0] dly[$];
    logic [4:0] mf;
    int run[5];
    logic m_ov, m_uv, m_ls, m_pg;

    always @(posedge clk) begin
        logic [4:0] old;
        logic [4:0] now_v;
        logic ov_prev, uv_prev;
        if (rst) begin
            dly.delete();
            dly.push_back(5'd0);
            dly.push_back(5'd0);
            mf = 5'd0;
            foreach (run[i]) run[i] = 0;
            m_ov = 0; m_uv = 0; m_ls = 0; m_pg = 0;
        end else begin
            now_v = {half, pglo, pghi, uv, ov};
            old = dly.pop_front();
            dly.push_back(now_v);
            ov_prev = m_ov;
            uv_prev = m_uv;
            if (mf[0]) m_ls = 1;
            else if (mf[4]) m_ls = 0;
            if (mf[1] && ss && !mf[0] && !ov_prev) m_uv = 1;
            if (mf[0]) m_ov = 1;
            m_pg = ss && !mf[0] && !mf[1] && !mf[2] && !mf[3] && !ov_prev && !uv_prev;
            for (int i = 0; i < 5; i++) begin
                if (old[i] != mf[i]) begin
                    run[i]++;
                    if (run[i] >= 2) begin
                        mf[i] = old[i];
                        run[i] = 0;
                    end
                end else begin
                    run[i] = 0;
                end
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R9 pgood (model)", pgood, m_pg);
            check("R2 ov_fault (model)", ov_fault, m_ov);
            check("R6 uv_fault (model)", uv_fault, m_uv);
            check("R3 hs_off (model)", hs_off, m_ov | m_uv);
            check("R4 ls_on (model)", ls_on, m_ls);
            check("R6 ls_off (model)", ls_off, m_uv & !m_ls);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; ov = 0; uv = 0; pghi = 0; pglo = 0; half = 0; ss = 0;
        cycles(3);
        rst = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // Reset state (R11) and power-good gating by soft-start (R9)
        cycles(1);
        rst = 1;
        cycles(2);
        check("R11 reset pgood", pgood, 0);
        check("R11 reset ov_fault", ov_fault, 0);
        check("R11 reset uv_fault", uv_fault, 0);
        check("R11 reset hs_off", hs_off, 0);
        check("R11 reset ls_on", ls_on, 0);
        check("R11 reset ls_off", ls_off, 0);
        rst = 0;
        cycles(10);
        check("R9 pgood before soft-start", pgood, 0);
        ss = 1;
        cycles(1);
        check("R9 pgood after soft-start", pgood, 1);

        // Window excursion and glitch rejection (R9, R1)
        pglo = 1;
        cycles(6);
        check("R9 pgood low outside window", pgood, 0);
        check("R9 no hs override on window", hs_off, 0);
        check("R9 no ls_on on window", ls_on, 0);
        check("R9 no ls_off on window", ls_off, 0);
        pglo = 0;
        cycles(6);
        check("R9 pgood back in window", pgood, 1);
        pghi = 1;
        cycles(1);
        pghi = 0;
        for (int k = 0; k < 8; k++) begin
            cycles(1);
            check("R1 pg glitch ignored", pgood, 1);
        end
        ov = 1;
        cycles(1);
        ov = 0;
        cycles(8);
        check("R1 ov glitch ignored fault", ov_fault, 0);
        check("R1 ov glitch ignored ls", ls_on, 0);

        // Overvoltage sequence (R1, R2, R3, R4, R5)
        ov = 1;
        cycles(4);
        check("R1 ov latency edge 4", ov_fault, 0);
        cycles(1);
        check("R1 ov latency edge 5", ov_fault, 1);
        check("R3 hs_off on ov", hs_off, 1);
        check("R4 ls_on on ov", ls_on, 1);
        check("R9 pgood low on ov", pgood, 0);
        ov = 0;
        cycles(8);
        check("R4 ls held above half", ls_on, 1);
        check("R2 ov_fault sticky", ov_fault, 1);
        ov = 1; half = 1;
        cycles(8);
        check("R4 ls held while ov present", ls_on, 1);
        ov = 0;
        cycles(8);
        check("R4 ls released below half", ls_on, 0);
        check("R2 ov_fault after release", ov_fault, 1);
        check("R3 hs_off after release", hs_off, 1);
        half = 0; ov = 1;
        cycles(6);
        check("R5 ls re-engaged", ls_on, 1);
        ov = 0;

        // Undervoltage (R7, R6, R10)
        do_reset();
        uv = 1;
        cycles(10);
        check("R7 uv masked before ss", uv_fault, 0);
        check("R7 no hs_off before ss", hs_off, 0);
        ss = 1;
        cycles(1);
        check("R6 uv latched", uv_fault, 1);
        check("R6 hs_off on uv", hs_off, 1);
        check("R6 ls_off on uv", ls_off, 1);
        check("R6 ls_on low on uv", ls_on, 0);
        uv = 0;
        cycles(8);
        check("R6 uv sticky", uv_fault, 1);
        ov = 1;
        cycles(6);
        check("R10 ls_on over uv", ls_on, 1);
        check("R10 ls_off dropped", ls_off, 0);
        ov = 0;

        // Simultaneous flags (R8)
        do_reset();
        ss = 1;
        cycles(2);
        ov = 1; uv = 1;
        cycles(6);
        check("R8 ov wins", ov_fault, 1);
        check("R8 uv suppressed", uv_fault, 0);
        ov = 0;
        cycles(10);
        check("R8 uv suppressed after ov", uv_fault, 0);
        uv = 0;

        // Floating sense pin (R11)
        rst = 1; uv = 0; half = 0; ss = 0; ov = 1;
        cycles(3);
        rst = 0;
        cycles(5);
        for (int k = 0; k < 20; k++) begin
            check("R11 floating pin holds ls_on", ls_on, 1);
            cycles(1);
        end

        done = 1;
        finish_run();
    end

endmodule